// File: doc/BRIEF.md
# Triangular Moving Sum Filter

A streaming smoothing filter for sampled data. Each accepted input sample produces one output that equals a window sum of window sums of length `WIN`. This is the same as a convolution with triangular weights 1, 2, …, `WIN`, …, 2, 1 spread over `2*WIN-1` taps. Its typical use is to flatten mains-frequency ripple picked up on a slow ADC channel before a threshold or trend stage.

The filter keeps a single history of raw input samples. It reads that history at delays `WIN` and `2*WIN` only, and folds both cascaded window sums into one recurrence. The cost per output is therefore two history reads and four add/subtract steps, whatever the window length, with no multiplier. The filter does not decimate and does not normalise the gain: the DC gain is `WIN*WIN`.

Top module: `tri_sum_filter`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `out_valid_o` is 0 and `out_data_o` is 0. The history and both accumulators restart at zero, so the first outputs after reset equal the convolution taken with all earlier samples counted as 0.
- R2: `out_valid_o` is high for exactly one cycle, in the cycle after a sample is accepted (the edge with `in_valid_i` high), and is never high otherwise.
- R3: For accepted sample n, `out_data_o` equals the sum over j = 0..2*WIN-2 of min(j+1, 2*WIN-1-j)·x[n-j], taken modulo 2^ACC_W as two's complement.
- R4: The first 2*WIN-1 accepted samples after reset produce no `out_valid_o`. The sample numbered 2*WIN after reset, and every later one, produces an `out_valid_o` pulse.
- R5: Cycles with `in_valid_i` low change no state: `out_data_o` holds its value, and later results are the same as if the idle cycles were absent.
- R6: Samples may arrive on every consecutive cycle, and each one yields its own result.
- R7: `in_data_i` is signed two's complement over DATA_W bits, including the most negative and most positive codes.
- R8: A constant input c, held for at least 2*WIN-1 samples, gives an output of WIN·WIN·c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Sample strobe; one sample per high cycle |
| in_data_i | input | DATA_W | Signed input sample |
| out_valid_o | output | 1 | Result strobe, one cycle after an accepted sample once warm |
| out_data_o | output | ACC_W | Signed filtered result |

## Verification
When a new sample arrives, the oldest history slot (delay 2*WIN) is read and that same slot is overwritten with the new sample, all in one clock edge. The output stays right only if the old value is consumed before it is replaced. The bench provokes this on every sample, and most sharply with back-to-back sweeps over every input code and with alternating full-scale extremes. It judges each result against a triangular convolution computed in the bench from its own copy of the input history. Idle gaps inserted at random positions also check that the read/write pairing stays aligned while the pointer is paused.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  // sign + K*K gain headroom + difference-term headroom
  function automatic int acc_width(input int data_w, input int win);
    return data_w + 2 * $clog2(win) + 2;
  endfunction
endpackage

// File: rtl/tsf_hist_ring.sv
module tsf_hist_ring #(
  parameter int DATA_W = 12,
  parameter int WIN    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] tap_k_o,
  output logic [DATA_W-1:0] tap_2k_o
);
  localparam int DEPTH = 2 * WIN;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] wr_ptr_q;
  logic [PTR_W-1:0] rd_k_ptr;
  logic [DEPTH-1:0][DATA_W-1:0] cells;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
    end else if (wr_en_i) begin
      wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + PTR_W'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [DATA_W-1:0] cell_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cell_q <= '0;
      end else if (wr_en_i && (wr_ptr_q == PTR_W'(g))) begin
        cell_q <= wr_data_i;
      end
    end
    assign cells[g] = cell_q;
  end

  // depth is exactly 2*WIN: the slot about to be written holds x[n-2K]
  always_comb begin
    if (wr_ptr_q >= PTR_W'(WIN)) rd_k_ptr = wr_ptr_q - PTR_W'(WIN);
    else                         rd_k_ptr = wr_ptr_q + PTR_W'(WIN);
  end

  assign tap_2k_o = cells[wr_ptr_q];
  assign tap_k_o  = cells[rd_k_ptr];
endmodule

// File: rtl/tsf_recur.sv
module tsf_recur #(
  parameter int DATA_W = 12,
  parameter int ACC_W  = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] x_k_i,
  input  logic [DATA_W-1:0] x_2k_i,
  output logic [ACC_W-1:0]  y_o
);
  localparam int EXT_W = ACC_W - DATA_W;

  logic [ACC_W-1:0] x_ext, xk_ext, x2k_ext;
  logic [ACC_W-1:0] delta, u_nxt, y_nxt;
  logic [ACC_W-1:0] u_q, y_q;

  assign x_ext   = {{EXT_W{x_i[DATA_W-1]}}, x_i};
  assign xk_ext  = {{EXT_W{x_k_i[DATA_W-1]}}, x_k_i};
  assign x2k_ext = {{EXT_W{x_2k_i[DATA_W-1]}}, x_2k_i};

  // second difference of the raw stream; wrap-around is exact
  assign delta = x_ext - {xk_ext[ACC_W-2:0], 1'b0} + x2k_ext;
  assign u_nxt = u_q + delta;
  assign y_nxt = y_q + u_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      u_q <= '0;
      y_q <= '0;
    end else if (en_i) begin
      u_q <= u_nxt;
      y_q <= y_nxt;
    end
  end

  assign y_o = y_q;
endmodule

// File: rtl/tsf_warmup.sv
module tsf_warmup #(
  parameter int WIN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic ready_o
);
  localparam int FILL  = 2 * WIN;
  localparam int CNT_W = $clog2(FILL + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i && (cnt_q != CNT_W'(FILL))) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // this sample is number FILL or later
  assign ready_o = en_i && (cnt_q >= CNT_W'(FILL - 1));
endmodule

// File: rtl/tri_sum_filter.sv
module tri_sum_filter
  import tsf_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int WIN    = 8,
  parameter int ACC_W  = acc_width(DATA_W, WIN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [ACC_W-1:0]  out_data_o
);
  logic [DATA_W-1:0] tap_k, tap_2k;
  logic              warm;
  logic              valid_q;

  tsf_hist_ring #(.DATA_W(DATA_W), .WIN(WIN)) u_ring (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (in_valid_i),
    .wr_data_i(in_data_i),
    .tap_k_o  (tap_k),
    .tap_2k_o (tap_2k)
  );

  tsf_recur #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_recur (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (in_valid_i),
    .x_i   (in_data_i),
    .x_k_i (tap_k),
    .x_2k_i(tap_2k),
    .y_o   (out_data_o)
  );

  tsf_warmup #(.WIN(WIN)) u_warm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (in_valid_i),
    .ready_o(warm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= warm;
  end

  assign out_valid_o = valid_q;
endmodule

// File: rtl/tri_sum_filter_chk.sv
module tri_sum_filter_chk #(
  parameter int DATA_W = 12,
  parameter int WIN    = 8,
  parameter int ACC_W  = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             out_valid_o,
  input logic [ACC_W-1:0] out_data_o
);
  localparam int FILL  = 2 * WIN;
  localparam int CNT_W = $clog2(FILL + 1);

  logic [CNT_W-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (in_valid_i && (seen_q != CNT_W'(FILL))) seen_q <= seen_q + CNT_W'(1);
  end

  AST_VALID_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i)); // R2

  AST_IDLE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R2

  AST_WARM_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (seen_q >= CNT_W'(FILL))); // R4

  AST_WARM_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (seen_q >= CNT_W'(FILL - 1))) |=> out_valid_o); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_data_o)); // R5
endmodule

bind tri_sum_filter tri_sum_filter_chk #(.DATA_W(DATA_W), .WIN(WIN), .ACC_W(ACC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o)
);

// File: tb/tri_sum_filter_tb_top.sv
module tri_sum_filter_tb_top;
  localparam int DW   = 6;
  localparam int K    = 4;
  localparam int AW   = tsf_pkg::acc_width(DW, K);
  localparam int TAPS = 2 * K - 1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [AW-1:0] out_data;

  tri_sum_filter #(.DATA_W(DW), .WIN(K)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid),
    .in_data_i  (in_data),
    .out_valid_o(out_valid),
    .out_data_o (out_data)
  );

  always #5 clk = ~clk;

  int            errors = 0;
  int            checks = 0;
  longint        hist[$];
  int            nacc = 0;
  logic [AW-1:0] y_last = '0;
  logic [15:0]   lfsr = 16'hACE1;

  function automatic longint weight(int j);
    int a = j + 1;
    int b = TAPS - j;
    return (a < b) ? a : b;
  endfunction

  function automatic logic [AW-1:0] model();
    longint     s = 0;
    logic [63:0] t;
    int n = hist.size();
    for (int j = 0; j < TAPS; j++)
      if (n - 1 - j >= 0) s += weight(j) * hist[n-1-j];
    t = s;
    return t[AW-1:0];
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sval(logic [AW-1:0] v);
    return longint'($signed(v));
  endfunction

  // inputs applied just after a falling edge, results read at the next one
  task automatic step(bit v, int x, string req);
    logic [AW-1:0] e;
    bit            exp_v;
    in_valid = v;
    in_data  = x[DW-1:0];
    @(negedge clk);
    if (v) begin
      hist.push_back(longint'($signed(x[DW-1:0])));
      nacc++;
    end
    exp_v = v && (nacc >= 2 * K);
    check(out_valid == exp_v, "R4/R2 valid", out_valid, exp_v);
    if (exp_v) begin
      e = model();
      check(out_data == e, req, sval(out_data), sval(e));
    end
    if (!v) check(out_data == y_last, "R5 hold", sval(out_data), sval(y_last));
    y_last   = out_data;
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    hist.delete();
    nacc = 0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    check(out_data == '0, "R1 data in reset", sval(out_data), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, "R1 after release", sval(out_data), 0);
    y_last = '0;
  endtask

  task automatic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    do_reset();

    // R3: impulse responses expose every triangular weight
    foreach (hist[i]) ;
    begin
      int amps[4] = '{1, -1, 31, -32};
      foreach (amps[a]) begin
        for (int i = 0; i < 2 * K; i++) step(1, 0, "R3 impulse lead");
        step(1, amps[a], "R3 impulse");
        for (int i = 0; i < TAPS + 2; i++) step(1, 0, "R3 impulse tail");
      end
    end

    // R8: DC gain is K*K
    begin
      int dcs[3] = '{7, -32, 31};
      foreach (dcs[d]) begin
        for (int i = 0; i < 3 * K; i++) step(1, dcs[d], "R8 dc");
        check(sval(out_data) == longint'(K * K * dcs[d]), "R8 dc gain",
              sval(out_data), K * K * dcs[d]);
      end
    end

    // R7: every input code, back to back
    for (int v = -(1 << (DW - 1)); v < (1 << (DW - 1)); v++) step(1, v, "R7 code sweep");

    // R6: full-scale alternation on consecutive cycles
    for (int i = 0; i < 4 * K; i++) step(1, (i % 2) ? -32 : 31, "R6 back-to-back");

    // R5: random data with random idle gaps
    for (int i = 0; i < 1500; i++) begin
      next_rand();
      step(lfsr[2:0] != 3'd0, int'($signed(lfsr[15:10])), "R5 gapped random");
    end

    // R1: reset mid-stream, history must restart at zero
    do_reset();
    for (int i = 0; i < 2 * K - 1; i++) step(1, 20 - 3 * i, "R1 warmup");
    for (int i = 0; i < 3 * K; i++) step(1, 5 * i - 30, "R1 zero history");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule